// File: doc/BRIEF.md
# Copy-Engine MMIO Register File

This block is the memory-mapped register front end of a multi-channel copy engine. A host issues byte-addressed reads and writes, and each access carries a size code for 1, 2, 4 or 8 bytes. The block decodes the offset into either the general register window or one of the per-channel windows. It applies the read and write side effects of the addressed register and returns one registered response per request. It also sends a one-cycle command strobe to the channel whose command byte was written.

Offsets 0x000 to 0x07F are the general window. Each later 0x80-byte window belongs to one channel: channel n sits at 0x80·(n+1). The general window holds:
- the channel count
- the transfer-capacity exponent
- the interrupt enable
- the attention bits

Each channel holds:
- a control word
- a command byte
- a status view
- two 64-bit addresses (descriptor chain and completion)
- an error word

The channel datapath drives the busy, status and error-set inputs. It reads the control word and the addresses from the outputs.

Top module: `ce_mmio_regfile`

## Requirements
- R1: An offset below 0x80 selects the general registers. An offset of 0x80 or more selects channel (offset>>7)−1 at register offset offset[6:0]. A channel index at or above NCHAN gives an error response and changes no state.
- R2: The channel count (general 0x00, 1 byte) reads NCHAN. The capacity register (general 0x01, 1 byte) reads the bit index of the highest set bit of XFER_CAP. Writes to either change nothing.
- R3: The attention word (general 0x04, 4 bytes) returns its value on a read and then clears. A write to it is ignored. Bits on attn_set are ORed in every cycle, and a set in the same cycle as a clearing read survives.
- R4: The interrupt control byte (general 0x02, 1 byte) holds the enable in bit 0, which also drives intr_en. A read returns it and then clears the enable. A write loads bit 0 of the data.
- R5: A channel's control word (offset 0x00, 2 bytes) is loaded whole by a write. A read returns the old value and then sets bit 8 (in-use).
- R6: For the chain address (0x10) and the completion address (0x18), an 8-byte write replaces all 64 bits. A 4-byte write replaces bits 31:0 and keeps the rest, and a 4-byte read returns bits 31:0. The high halves at 0x14 and 0x1C (4 bytes) read and replace only bits 63:32.
- R7: The error word (0x20, 4 bytes) clears each bit written as 1. Bits on the channel's error-set input are ORed in and win over a clear in the same cycle.
- R8: A 1-byte write to the command register (0x02) raises cmd_pulse for that channel alone, for exactly one cycle, with the byte on its cmd_code lane. The register then reads 0.
- R9: The status view (0x08, 8 bytes) reads the channel's status input ORed with an idle flag in bit 0 (1 when not busy). Writes to it are ignored.
- R10: A size not allowed for the addressed register, or an unmapped offset, gives rsp_err=1 with zero data and no side effect.
- R11: Each request gets exactly one response one cycle later (rsp_valid). A write response carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_size | input | 2 | 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 bytes |
| req_wdata | input | 64 | Write data, right-aligned |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, right-aligned, zero on error or write |
| rsp_err | output | 1 | Access was illegal |
| attn_set | input | 32 | Attention bits to set |
| chan_busy | input | NCHAN | Per-channel busy flag |
| chan_stat | input | NCHAN*64 | Per-channel status word |
| chan_err_set | input | NCHAN*32 | Per-channel error bits to set |
| intr_en | output | 1 | Master interrupt enable |
| cmd_pulse | output | NCHAN | One-cycle command strobe per channel |
| cmd_code | output | NCHAN*8 | Command byte per channel |
| chan_ctrl | output | NCHAN*16 | Control word per channel |
| chain_addr | output | NCHAN*64 | Descriptor chain address per channel |
| cmpl_addr | output | NCHAN*64 | Completion address per channel |

## Verification
The hardest cases to reach from the ports are collisions between a hardware set and a software clear in the same clock. Examples are an attention read while attn_set is active, and an error write-one-to-clear while the same bits are being set. The bench drives the set inputs in the same cycle as the clearing access, both in directed cases and in the random phase. Random traffic also mixes legal sizes with wrong sizes, unmapped offsets and out-of-range channel windows. Later reads then show that illegal accesses left every register untouched.

// File: rtl/ce_mmio_pkg.sv
`timescale 1ns/1ps
package ce_mmio_pkg;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [3:0] {
    RID_NONE, RID_CHCNT, RID_CAP, RID_INTR, RID_ATTN,
    RID_CTRL, RID_CMD, RID_STAT, RID_CHAIN, RID_CHAINHI,
    RID_CMPL, RID_CMPLHI, RID_ERR
  } reg_id_e;

  // general window offsets
  localparam logic [6:0] GOFF_CHCNT = 7'h00;
  localparam logic [6:0] GOFF_CAP   = 7'h01;
  localparam logic [6:0] GOFF_INTR  = 7'h02;
  localparam logic [6:0] GOFF_ATTN  = 7'h04;

  // channel window offsets
  localparam logic [6:0] COFF_CTRL    = 7'h00;
  localparam logic [6:0] COFF_CMD     = 7'h02;
  localparam logic [6:0] COFF_STAT    = 7'h08;
  localparam logic [6:0] COFF_CHAIN   = 7'h10;
  localparam logic [6:0] COFF_CHAINHI = 7'h14;
  localparam logic [6:0] COFF_CMPL    = 7'h18;
  localparam logic [6:0] COFF_CMPLHI  = 7'h1C;
  localparam logic [6:0] COFF_ERR     = 7'h20;

  localparam int CTRL_INUSE_BIT = 8;
  localparam int ATTN_W         = 32;
  localparam int ERR_W          = 32;

  function automatic int msb_index(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (((v >> i) & 1) != 0) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/ce_mmio_decode.sv
`timescale 1ns/1ps
module ce_mmio_decode
  import ce_mmio_pkg::*;
#(
  parameter int NCHAN  = 4,
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  acc_size_e         size,
  output reg_id_e           rid,
  output logic [IDX_W-1:0]  chan_idx,
  output logic              legal
);
  localparam int WIN_W = ADDR_W - 7;

  logic [WIN_W-1:0] win;
  logic [WIN_W-1:0] widx;
  logic [6:0]       off;
  logic             size_ok;
  logic             in_range;

  assign win = addr[ADDR_W-1:7];
  assign off = addr[6:0];

  always_comb begin
    rid      = RID_NONE;
    size_ok  = 1'b0;
    in_range = 1'b1;
    widx     = win - WIN_W'(1);
    chan_idx = widx[IDX_W-1:0];
    if (win == '0) begin
      case (off)
        GOFF_CHCNT: begin rid = RID_CHCNT; size_ok = (size == SZ_B); end
        GOFF_CAP:   begin rid = RID_CAP;   size_ok = (size == SZ_B); end
        GOFF_INTR:  begin rid = RID_INTR;  size_ok = (size == SZ_B); end
        GOFF_ATTN:  begin rid = RID_ATTN;  size_ok = (size == SZ_W); end
        default:    rid = RID_NONE;
      endcase
    end else begin
      in_range = (32'(widx) < 32'(NCHAN));
      case (off)
        COFF_CTRL:    begin rid = RID_CTRL;    size_ok = (size == SZ_H); end
        COFF_CMD:     begin rid = RID_CMD;     size_ok = (size == SZ_B); end
        COFF_STAT:    begin rid = RID_STAT;    size_ok = (size == SZ_D); end
        COFF_CHAIN:   begin rid = RID_CHAIN;   size_ok = (size == SZ_W) || (size == SZ_D); end
        COFF_CHAINHI: begin rid = RID_CHAINHI; size_ok = (size == SZ_W); end
        COFF_CMPL:    begin rid = RID_CMPL;    size_ok = (size == SZ_W) || (size == SZ_D); end
        COFF_CMPLHI:  begin rid = RID_CMPLHI;  size_ok = (size == SZ_W); end
        COFF_ERR:     begin rid = RID_ERR;     size_ok = (size == SZ_W); end
        default:      rid = RID_NONE;
      endcase
    end
    legal = (rid != RID_NONE) && size_ok && in_range;
  end

endmodule

// File: rtl/ce_gen_regs.sv
`timescale 1ns/1ps
module ce_gen_regs
  import ce_mmio_pkg::*;
#(
  parameter int NCHAN    = 4,
  parameter int XFER_CAP = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  reg_id_e           rid,
  input  logic [7:0]        wdata,
  input  logic [ATTN_W-1:0] attn_set,
  output logic [63:0]       rdata,
  output logic              intr_en
);
  localparam int CAP_MSB = msb_index(XFER_CAP);

  logic              wr, rd;
  logic              intr_q, intr_d, intr_ce;
  logic [ATTN_W-1:0] attn_q, attn_d;
  logic              attn_ce;

  assign wr = acc_en &&  acc_wr;
  assign rd = acc_en && !acc_wr;

  // next state
  always_comb begin
    intr_ce = (wr || rd) && (rid == RID_INTR);
    intr_d  = wr ? wdata[0] : 1'b0;
    attn_ce = (rd && (rid == RID_ATTN)) || (|attn_set);
    attn_d  = ((rd && (rid == RID_ATTN)) ? '0 : attn_q) | attn_set;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intr_q <= 1'b0;
      attn_q <= '0;
    end else begin
      if (intr_ce) intr_q <= intr_d;
      if (attn_ce) attn_q <= attn_d;
    end
  end

  always_comb begin
    case (rid)
      RID_CHCNT: rdata = {56'd0, 8'(NCHAN)};
      RID_CAP:   rdata = {56'd0, 8'(CAP_MSB)};
      RID_INTR:  rdata = {63'd0, intr_q};
      RID_ATTN:  rdata = {{(64-ATTN_W){1'b0}}, attn_q};
      default:   rdata = '0;
    endcase
  end

  assign intr_en = intr_q;

  // R4: a read of the interrupt byte leaves the enable cleared
  a_r4_read_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rid == RID_INTR) |=> !intr_en);

  // R3: after a clearing read only the bits set in that cycle remain
  a_r3_read_clears_attn: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rid == RID_ATTN) |=> (attn_q == $past(attn_set)));

  // R3: writes never clear attention bits
  a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rid == RID_ATTN) |=> ((attn_q & $past(attn_q)) == $past(attn_q)));

endmodule

// File: rtl/ce_chan_regs.sv
`timescale 1ns/1ps
module ce_chan_regs
  import ce_mmio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_wr,
  input  reg_id_e          rid,
  input  acc_size_e        size,
  input  logic [63:0]      wdata,
  input  logic             busy,
  input  logic [63:0]      stat_in,
  input  logic [ERR_W-1:0] err_set,
  output logic [63:0]      rdata,
  output logic [15:0]      ctrl,
  output logic [63:0]      chain,
  output logic [63:0]      cmpl,
  output logic             cmd_pulse,
  output logic [7:0]       cmd_code
);
  localparam logic [15:0] INUSE_MASK = 16'(1) << CTRL_INUSE_BIT;

  logic             wr, rd;
  logic [15:0]      ctrl_q, ctrl_d;
  logic             ctrl_ce;
  logic [63:0]      chain_q, chain_d, cmpl_q, cmpl_d;
  logic             chain_ce, cmpl_ce;
  logic [ERR_W-1:0] err_q, err_d;
  logic             err_ce;
  logic [7:0]       cmd_q, cmd_d;
  logic             pend_q, pend_d, cmd_ce;
  logic             cmd_wr, err_wr;

  assign wr     = acc_en &&  acc_wr;
  assign rd     = acc_en && !acc_wr;
  assign cmd_wr = wr && (rid == RID_CMD);
  assign err_wr = wr && (rid == RID_ERR);

  // next state
  always_comb begin
    ctrl_ce = (wr || rd) && (rid == RID_CTRL);
    ctrl_d  = wr ? wdata[15:0] : (ctrl_q | INUSE_MASK);

    chain_ce = wr && ((rid == RID_CHAIN) || (rid == RID_CHAINHI));
    if (rid == RID_CHAINHI)  chain_d = {wdata[31:0], chain_q[31:0]};
    else if (size == SZ_D)   chain_d = wdata;
    else                     chain_d = {chain_q[63:32], wdata[31:0]};

    cmpl_ce = wr && ((rid == RID_CMPL) || (rid == RID_CMPLHI));
    if (rid == RID_CMPLHI)   cmpl_d = {wdata[31:0], cmpl_q[31:0]};
    else if (size == SZ_D)   cmpl_d = wdata;
    else                     cmpl_d = {cmpl_q[63:32], wdata[31:0]};

    err_ce = err_wr || (|err_set);
    err_d  = (err_wr ? (err_q & ~wdata[ERR_W-1:0]) : err_q) | err_set;

    cmd_ce = cmd_wr || pend_q;
    cmd_d  = cmd_wr ? wdata[7:0] : 8'd0;
    pend_d = cmd_wr;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      chain_q <= '0;
      cmpl_q  <= '0;
      err_q   <= '0;
      cmd_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (ctrl_ce)  ctrl_q  <= ctrl_d;
      if (chain_ce) chain_q <= chain_d;
      if (cmpl_ce)  cmpl_q  <= cmpl_d;
      if (err_ce)   err_q   <= err_d;
      if (cmd_ce) begin
        cmd_q  <= cmd_d;
        pend_q <= pend_d;
      end
    end
  end

  always_comb begin
    case (rid)
      RID_CTRL:    rdata = {48'd0, ctrl_q};
      RID_CMD:     rdata = {56'd0, cmd_q};
      RID_STAT:    rdata = stat_in | {63'd0, ~busy};
      RID_CHAIN:   rdata = (size == SZ_D) ? chain_q : {32'd0, chain_q[31:0]};
      RID_CHAINHI: rdata = {32'd0, chain_q[63:32]};
      RID_CMPL:    rdata = (size == SZ_D) ? cmpl_q : {32'd0, cmpl_q[31:0]};
      RID_CMPLHI:  rdata = {32'd0, cmpl_q[63:32]};
      RID_ERR:     rdata = {{(64-ERR_W){1'b0}}, err_q};
      default:     rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign chain     = chain_q;
  assign cmpl      = cmpl_q;
  assign cmd_pulse = pend_q;
  assign cmd_code  = cmd_q;

  // R8: the strobe lasts one cycle and the byte returns to zero behind it
  a_r8_cmd_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !cmd_wr) |=> (!cmd_pulse && cmd_code == 8'd0));

  // R5: a control read leaves the in-use bit set
  a_r5_inuse_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rid == RID_CTRL) |=> ctrl[CTRL_INUSE_BIT]);

  // R6: a 4-byte write to the low half keeps the high half
  a_r6_low_write_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rid == RID_CHAIN && size == SZ_W) |=> (chain[63:32] == $past(chain[63:32])));

  // R6: a high-half write keeps the low half
  a_r6_high_write_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && rid == RID_CMPLHI) |=> (cmpl[31:0] == $past(cmpl[31:0])));

  // R7: written ones are gone unless hardware set them again
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr |=> ((err_q & $past(wdata[ERR_W-1:0]) & ~$past(err_set)) == '0));

endmodule

// File: rtl/ce_mmio_regfile.sv
`timescale 1ns/1ps
module ce_mmio_regfile
  import ce_mmio_pkg::*;
#(
  parameter int NCHAN    = 4,
  parameter int ADDR_W   = 12,
  parameter int XFER_CAP = 4096
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic [63:0]         req_wdata,
  output logic                rsp_valid,
  output logic [63:0]         rsp_rdata,
  output logic                rsp_err,
  input  logic [ATTN_W-1:0]   attn_set,
  input  logic [NCHAN-1:0]    chan_busy,
  input  logic [NCHAN*64-1:0] chan_stat,
  input  logic [NCHAN*ERR_W-1:0] chan_err_set,
  output logic                intr_en,
  output logic [NCHAN-1:0]    cmd_pulse,
  output logic [NCHAN*8-1:0]  cmd_code,
  output logic [NCHAN*16-1:0] chan_ctrl,
  output logic [NCHAN*64-1:0] chain_addr,
  output logic [NCHAN*64-1:0] cmpl_addr
);
  localparam int IDX_W = (NCHAN > 1) ? $clog2(NCHAN) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_s0, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s0     <= 1'b1;
      rst_sync_n <= rst_s0;
    end
  end

  reg_id_e          dec_rid;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_legal;
  logic             acc_ok, is_gen;
  logic [63:0]      gen_rdata;
  logic [63:0]      chan_rdata [NCHAN];
  logic [63:0]      rd_sel;

  ce_mmio_decode #(.NCHAN(NCHAN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr     (req_addr),
    .size     (acc_size_e'(req_size)),
    .rid      (dec_rid),
    .chan_idx (dec_idx),
    .legal    (dec_legal)
  );

  assign acc_ok = req_valid && dec_legal;
  assign is_gen = dec_rid inside {RID_CHCNT, RID_CAP, RID_INTR, RID_ATTN};

  ce_gen_regs #(.NCHAN(NCHAN), .XFER_CAP(XFER_CAP)) u_gen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_en   (acc_ok && is_gen),
    .acc_wr   (req_write),
    .rid      (dec_rid),
    .wdata    (req_wdata[7:0]),
    .attn_set (attn_set),
    .rdata    (gen_rdata),
    .intr_en  (intr_en)
  );

  for (genvar i = 0; i < NCHAN; i++) begin : g_chan
    ce_chan_regs u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .acc_en    (acc_ok && !is_gen && (dec_idx == IDX_W'(i))),
      .acc_wr    (req_write),
      .rid       (dec_rid),
      .size      (acc_size_e'(req_size)),
      .wdata     (req_wdata),
      .busy      (chan_busy[i]),
      .stat_in   (chan_stat[i*64 +: 64]),
      .err_set   (chan_err_set[i*ERR_W +: ERR_W]),
      .rdata     (chan_rdata[i]),
      .ctrl      (chan_ctrl[i*16 +: 16]),
      .chain     (chain_addr[i*64 +: 64]),
      .cmpl      (cmpl_addr[i*64 +: 64]),
      .cmd_pulse (cmd_pulse[i]),
      .cmd_code  (cmd_code[i*8 +: 8])
    );
  end

  assign rd_sel = is_gen ? gen_rdata : chan_rdata[dec_idx];

  // response: next state and register
  logic        rv_d, re_d;
  logic [63:0] rd_d;
  always_comb begin
    rv_d = req_valid;
    re_d = req_valid && !dec_legal;
    rd_d = (acc_ok && !req_write) ? rd_sel : 64'd0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_err   <= re_d;
      rsp_rdata <= rd_d;
    end
  end

  // R11: one response per request, one cycle later
  a_r11_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  a_r11_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);

  // R10: an error response carries no data
  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (rsp_rdata == 64'd0));

  // R8: at most one channel strobed at a time
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(cmd_pulse));

  // R1: a rejected access never strobes a channel
  a_r1_bad_access_no_cmd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_err |-> (cmd_pulse == '0));

endmodule

// File: tb/tb_ce_mmio_regfile.sv
`timescale 1ns/1ps
module tb_ce_mmio_regfile;
  localparam int NCHAN    = 4;
  localparam int ADDR_W   = 12;
  localparam int XFER_CAP = 4096;

  localparam int K_NONE = 0, K_CHCNT = 1, K_CAP = 2, K_INTR = 3, K_ATTN = 4,
                 K_CTRL = 5, K_CMD = 6, K_STAT = 7, K_CHAIN = 8, K_CHAINHI = 9,
                 K_CMPL = 10, K_CMPLHI = 11, K_ERR = 12;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  req_valid, req_write;
  logic [ADDR_W-1:0]     req_addr;
  logic [1:0]            req_size;
  logic [63:0]           req_wdata;
  logic                  rsp_valid, rsp_err;
  logic [63:0]           rsp_rdata;
  logic [31:0]           attn_set;
  logic [NCHAN-1:0]      chan_busy;
  logic [NCHAN*64-1:0]   chan_stat;
  logic [NCHAN*32-1:0]   chan_err_set;
  logic                  intr_en;
  logic [NCHAN-1:0]      cmd_pulse;
  logic [NCHAN*8-1:0]    cmd_code;
  logic [NCHAN*16-1:0]   chan_ctrl;
  logic [NCHAN*64-1:0]   chain_addr, cmpl_addr;

  always #2.5 clk = ~clk;

  ce_mmio_regfile #(.NCHAN(NCHAN), .ADDR_W(ADDR_W), .XFER_CAP(XFER_CAP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .attn_set(attn_set), .chan_busy(chan_busy), .chan_stat(chan_stat),
    .chan_err_set(chan_err_set), .intr_en(intr_en), .cmd_pulse(cmd_pulse),
    .cmd_code(cmd_code), .chan_ctrl(chan_ctrl), .chain_addr(chain_addr),
    .cmpl_addr(cmpl_addr)
  );

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  logic        m_intr;
  logic [31:0] m_attn;
  logic [15:0] m_ctrl  [NCHAN];
  logic [63:0] m_chain [NCHAN];
  logic [63:0] m_cmpl  [NCHAN];
  logic [31:0] m_err   [NCHAN];

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic int cap_msb();
    int r = 0;
    for (int i = 0; i < 32; i++) if (((XFER_CAP >> i) & 1) != 0) r = i;
    return r;
  endfunction

  function automatic int classify(input logic [ADDR_W-1:0] a, input logic [1:0] sz, output int ch);
    int win, off, k;
    win = int'(a >> 7);
    off = int'(a & 12'h7f);
    k   = K_NONE;
    ch  = 0;
    if (win == 0) begin
      case (off)
        'h00: k = (sz == 0) ? K_CHCNT : K_NONE;
        'h01: k = (sz == 0) ? K_CAP   : K_NONE;
        'h02: k = (sz == 0) ? K_INTR  : K_NONE;
        'h04: k = (sz == 2) ? K_ATTN  : K_NONE;
        default: k = K_NONE;
      endcase
    end else begin
      ch = win - 1;
      if (ch >= NCHAN) return K_NONE;
      case (off)
        'h00: k = (sz == 1) ? K_CTRL : K_NONE;
        'h02: k = (sz == 0) ? K_CMD  : K_NONE;
        'h08: k = (sz == 3) ? K_STAT : K_NONE;
        'h10: k = (sz >= 2) ? K_CHAIN : K_NONE;
        'h14: k = (sz == 2) ? K_CHAINHI : K_NONE;
        'h18: k = (sz >= 2) ? K_CMPL : K_NONE;
        'h1C: k = (sz == 2) ? K_CMPLHI : K_NONE;
        'h20: k = (sz == 2) ? K_ERR : K_NONE;
        default: k = K_NONE;
      endcase
    end
    return k;
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      K_CHCNT, K_CAP: return "R2";
      K_INTR:  return "R4";
      K_ATTN:  return "R3";
      K_CTRL:  return "R5";
      K_CMD:   return "R8";
      K_STAT:  return "R9";
      K_ERR:   return "R7";
      K_NONE:  return "R10";
      default: return "R6";
    endcase
  endfunction

  task automatic access(input bit wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                        input logic [63:0] wd, input logic [31:0] aset,
                        input int ech, input logic [31:0] eset);
    int k, ch;
    logic [63:0] exp_rd;
    logic [NCHAN-1:0] exp_pulse;
    logic [7:0] exp_code;
    string tag;
    k = classify(a, sz, ch);
    tag = tag_of(k);
    exp_rd = 64'd0;
    exp_pulse = '0;
    exp_code = 8'd0;
    if (k != K_NONE && !wr) begin
      case (k)
        K_CHCNT:   exp_rd = 64'(NCHAN);
        K_CAP:     exp_rd = 64'(cap_msb());
        K_INTR:    exp_rd = {63'd0, m_intr};
        K_ATTN:    exp_rd = {32'd0, m_attn};
        K_CTRL:    exp_rd = {48'd0, m_ctrl[ch]};
        K_CMD:     exp_rd = 64'd0;
        K_STAT:    exp_rd = chan_stat[ch*64 +: 64] | {63'd0, ~chan_busy[ch]};
        K_CHAIN:   exp_rd = (sz == 3) ? m_chain[ch] : {32'd0, m_chain[ch][31:0]};
        K_CHAINHI: exp_rd = {32'd0, m_chain[ch][63:32]};
        K_CMPL:    exp_rd = (sz == 3) ? m_cmpl[ch] : {32'd0, m_cmpl[ch][31:0]};
        K_CMPLHI:  exp_rd = {32'd0, m_cmpl[ch][63:32]};
        K_ERR:     exp_rd = {32'd0, m_err[ch]};
        default:   exp_rd = 64'd0;
      endcase
    end
    if (k != K_NONE) begin
      if (wr) begin
        case (k)
          K_INTR:    m_intr = wd[0];
          K_CTRL:    m_ctrl[ch] = wd[15:0];
          K_CMD:     begin exp_pulse[ch] = 1'b1; exp_code = wd[7:0]; end
          K_CHAIN:   m_chain[ch] = (sz == 3) ? wd : {m_chain[ch][63:32], wd[31:0]};
          K_CHAINHI: m_chain[ch] = {wd[31:0], m_chain[ch][31:0]};
          K_CMPL:    m_cmpl[ch] = (sz == 3) ? wd : {m_cmpl[ch][63:32], wd[31:0]};
          K_CMPLHI:  m_cmpl[ch] = {wd[31:0], m_cmpl[ch][31:0]};
          K_ERR:     m_err[ch] = m_err[ch] & ~wd[31:0];
          default:   ;
        endcase
      end else begin
        case (k)
          K_INTR: m_intr = 1'b0;
          K_ATTN: m_attn = 32'd0;
          K_CTRL: m_ctrl[ch] = m_ctrl[ch] | 16'h0100;
          default: ;
        endcase
      end
    end
    m_attn = m_attn | aset;
    if (ech >= 0) m_err[ech] = m_err[ech] | eset;

    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_size  = sz;
    req_wdata = wd;
    attn_set  = aset;
    chan_err_set = '0;
    if (ech >= 0) chan_err_set[ech*32 +: 32] = eset;
    @(negedge clk);
    req_valid = 1'b0;
    attn_set  = '0;
    chan_err_set = '0;
    chk("R11", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk("R1,R10", "rsp_err", 64'(rsp_err), 64'(k == K_NONE));
    chk(tag, "rsp_rdata", rsp_rdata, exp_rd);
    chk("R8", "cmd_pulse", 64'(cmd_pulse), 64'(exp_pulse));
    if (exp_pulse != '0) chk("R8", "cmd_code", 64'(cmd_code[ch*8 +: 8]), 64'(exp_code));
    @(negedge clk);
    chk("R8", "cmd_pulse after", 64'(cmd_pulse), 64'd0);
    chk("R11", "rsp_valid idle", 64'(rsp_valid), 64'd0);
    chk("R4", "intr_en port", 64'(intr_en), 64'(m_intr));
    for (int c = 0; c < NCHAN; c++) begin
      chk("R5", "chan_ctrl port", 64'(chan_ctrl[c*16 +: 16]), 64'(m_ctrl[c]));
      chk("R6", "chain_addr port", chain_addr[c*64 +: 64], m_chain[c]);
      chk("R6", "cmpl_addr port", cmpl_addr[c*64 +: 64], m_cmpl[c]);
    end
  endtask

  function automatic logic [ADDR_W-1:0] caddr(input int ch, input int off);
    return ADDR_W'(((ch + 1) << 7) | off);
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int gen_offs[4];
    int ch_offs[8];
    gen_offs = '{'h00, 'h01, 'h02, 'h04};
    ch_offs  = '{'h00, 'h02, 'h08, 'h10, 'h14, 'h18, 'h1C, 'h20};
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = '0; req_wdata = '0;
    attn_set = '0; chan_err_set = '0;
    for (int c = 0; c < NCHAN; c++) begin
      chan_busy[c] = 1'($urandom);
      chan_stat[c*64 +: 64] = {$urandom, $urandom};
      m_ctrl[c] = '0; m_chain[c] = '0; m_cmpl[c] = '0; m_err[c] = '0;
    end
    m_intr = 1'b0; m_attn = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R11", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R8", "reset cmd_pulse", 64'(cmd_pulse), 64'd0);
    chk("R4", "reset intr_en", 64'(intr_en), 64'd0);
    chk("R6", "reset chain_addr", chain_addr[63:0], 64'd0);

    // R2 read-only identity registers
    access(0, 12'h000, 0, 0, 0, -1, 0);
    access(1, 12'h000, 0, 64'hFF, 0, -1, 0);
    access(0, 12'h000, 0, 0, 0, -1, 0);
    access(1, 12'h001, 0, 64'h3, 0, -1, 0);
    access(0, 12'h001, 0, 0, 0, -1, 0);
    // R4 enable write then clearing read
    access(1, 12'h002, 0, 64'h1, 0, -1, 0);
    access(0, 12'h002, 0, 0, 0, -1, 0);
    access(0, 12'h002, 0, 0, 0, -1, 0);
    // R3 set, ignored write, read colliding with a new set
    access(0, 12'h000, 0, 0, 32'h0000_00F0, -1, 0);
    access(1, 12'h004, 2, 64'hFFFF_FFFF, 0, -1, 0);
    access(0, 12'h004, 2, 0, 32'h0000_0003, -1, 0);
    access(0, 12'h004, 2, 0, 0, -1, 0);
    // R7 error set and clear in the same cycle
    access(0, 12'h000, 0, 0, 0, 2, 32'h0000_FF00);
    access(1, caddr(2, 'h20), 2, 64'h0000_0F00, 0, 2, 32'h0000_0100);
    access(0, caddr(2, 'h20), 2, 0, 0, -1, 0);
    // R6 partial updates
    access(1, caddr(1, 'h10), 3, 64'h1111_2222_3333_4444, 0, -1, 0);
    access(1, caddr(1, 'h10), 2, 64'hAAAA_BBBB_CCCC_DDDD, 0, -1, 0);
    access(1, caddr(1, 'h14), 2, 64'h0000_0000_5555_6666, 0, -1, 0);
    access(0, caddr(1, 'h10), 3, 0, 0, -1, 0);
    access(1, caddr(3, 'h1C), 2, 64'h0000_0000_7777_8888, 0, -1, 0);
    access(0, caddr(3, 'h18), 2, 0, 0, -1, 0);
    // R5 in-use bit and R8 command strobe, R9 status
    access(1, caddr(0, 'h00), 1, 64'h0000_0000_0000_00A5, 0, -1, 0);
    access(0, caddr(0, 'h00), 1, 0, 0, -1, 0);
    access(0, caddr(0, 'h00), 1, 0, 0, -1, 0);
    access(1, caddr(3, 'h02), 0, 64'h0000_0000_0000_005C, 0, -1, 0);
    access(0, caddr(3, 'h02), 0, 0, 0, -1, 0);
    access(1, caddr(2, 'h08), 3, 64'hFFFF_FFFF_FFFF_FFFF, 0, -1, 0);
    access(0, caddr(2, 'h08), 3, 0, 0, -1, 0);
    // R1 out-of-range channel and R10 bad size, then state unchanged
    access(1, ADDR_W'(((NCHAN + 1) << 7) | 'h10), 3, 64'hDEAD_BEEF_0000_0001, 0, -1, 0);
    access(1, caddr(1, 'h10), 1, 64'h0BAD_0BAD_0BAD_0BAD, 0, -1, 0);
    access(1, caddr(0, 'h40), 2, 64'h1234, 0, -1, 0);
    access(0, caddr(1, 'h10), 3, 0, 0, -1, 0);

    // constrained random mix
    for (int n = 0; n < 600; n++) begin
      int win, off, ch, k, ech;
      logic [1:0] sz;
      logic [ADDR_W-1:0] a;
      logic [31:0] aset, eset;
      win = int'($urandom % (NCHAN + 2));
      if (($urandom % 5) != 0) off = (win == 0) ? gen_offs[$urandom % 4] : ch_offs[$urandom % 8];
      else off = int'($urandom % 128);
      a = ADDR_W'((win << 7) | off);
      sz = 2'($urandom);
      if (($urandom % 10) < 7) begin
        for (int t = 0; t < 8; t++) begin
          k = classify(a, sz, ch);
          if (k != K_NONE) break;
          sz = 2'($urandom);
        end
      end
      aset = (($urandom % 8) == 0) ? 32'(1 << ($urandom % 32)) : 32'd0;
      ech  = (($urandom % 8) == 0) ? int'($urandom % NCHAN) : -1;
      eset = (ech >= 0) ? 32'(1 << ($urandom % 32)) : 32'd0;
      access(1'($urandom), a, sz, {$urandom, $urandom}, aset, ech, eset);
    end

    finish_run();
  end

endmodule